// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block is the receive-side memory writer of a small network controller. It takes received frame bytes, one per clock, from a byte stream framed by start and end strobes. It stores them in a circular area of local buffer memory that is divided into 256-byte pages. The ring is bounded below by a first-page input and above by a limit-page input. A guard page, which the host owns, marks how far the writer may go before it would overwrite data the host has not yet consumed.

Each accepted frame begins at the page held in the block's current-page register. Payload goes in from byte 4 of that page onward. Bytes 0 to 3 of the page are left free for a header. After the last payload byte (plus any zero padding that brings a short frame up to 60 bytes), the header is written in four extra cycles: status, next page, and the total length as low byte then high byte. The current page then advances to the page after the frame.

Frames whose first destination byte has bit 0 set are group frames. A group frame is kept only if broadcast acceptance is enabled and its six destination bytes are all 0xFF. If the writer reaches the guard page, the frame is abandoned as an overrun and a missed-frame counter advances. Completion and overrun each set a sticky interrupt-status bit. The host clears these bits by writing ones, and an interrupt line reports any status bit that is enabled in a mask.

The controller is a five-state machine:
- ST_IDLE waits for a start strobe.
- ST_RECV stores bytes.
- ST_PAD writes zero fill.
- ST_HDR writes the four header bytes.
- ST_SKIP discards the rest of a rejected or overrun frame.

Its transitions are:
- IDLE→RECV on an accepted first byte.
- IDLE/RECV→PAD at a short frame's end.
- IDLE/RECV→HDR at a long frame's end.
- PAD→HDR when 60 bytes are stored.
- HDR→IDLE after the fourth header byte.
- IDLE/RECV→SKIP on a reject or overrun before the end strobe, or →IDLE when that byte is the last.
- SKIP→IDLE on the end strobe.

Top module: `rxring_writer`

## Requirements
- R1: After reset, mem_we, rx_busy and irq are 0, and cur_page, rx_status, int_status and missed_cnt are all zero.
- R2: A frame starts at page S, where S is cur_page, or pg_first when cur_page equals pg_last. Payload byte k is written at address {S, 8'h04} + k, one write per received byte, in arrival order, with the write appearing one cycle after the byte is sampled.
- R3: When the write address crosses into a new page, a new page equal to pg_last is replaced by pg_first, so the frame continues at offset 0 of pg_first.
- R4: If the page entered at a crossing equals pg_guard, the frame is abandoned after that byte. rx_status becomes 0x10, int_status bit 4 is set, missed_cnt increments by one, cur_page is unchanged, and nothing more is written until the next start strobe.
- R5: A frame whose first byte has bit 0 set is a group frame. It is dropped at the first of its six leading bytes that is not 0xFF, or at its first byte when accept_bcast is 0. A dropped frame writes no header and changes neither cur_page, rx_status nor int_status.
- R6: A kept frame with fewer than 60 payload bytes is followed by zero bytes at consecutive addresses until 60 bytes are stored, and its length is taken as 60.
- R7: After the payload and padding, four writes go to {S,8'h00}..{S,8'h03}. They carry, in that order: the status, the next page, the low byte of (length+4), and the high byte of (length+4). The status is 0x01 for a unicast frame and 0x21 for an accepted broadcast, and rx_status takes the same value.
- R8: The next page is the page after the last written byte, rounded up to a whole page and replaced by pg_first if it equals pg_last. It is loaded into cur_page, and int_status bit 0 is set, when the last header byte is written.
- R9: Writing 1s on int_status_clr clears those int_status bits in the next cycle. irq is 1 exactly when int_status AND int_mask is nonzero.
- R10: rx_busy is 1 while padding or header bytes are written, and input bytes presented then are ignored and cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Input byte |
| pg_first | input | PG_W | First page of the ring |
| pg_last | input | PG_W | Page one past the ring's end |
| pg_guard | input | PG_W | Page the writer must not enter |
| accept_bcast | input | 1 | Keep all-ones broadcast frames |
| cur_wr_en | input | 1 | Load cur_page from cur_wr_val |
| cur_wr_val | input | PG_W | Value for cur_page load |
| int_status_clr | input | 8 | Write-one-to-clear for int_status |
| int_mask | input | 8 | Interrupt enable per status bit |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PG_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PG_W | Page where the next frame starts |
| rx_status | output | 8 | Status of the last completed or overrun frame |
| int_status | output | 8 | Sticky interrupt status (bit 0 done, bit 4 overrun) |
| missed_cnt | output | CNT_W | Overrun frame count |
| irq | output | 1 | Interrupt request |
| rx_busy | output | 1 | Padding or header in progress |

## Verification
The bench predicts every memory write for each frame, including the header, and compares the writes in order as they appear.

Unicast frames of 64, 20, 300 and 400 bytes separate several behaviours:
- plain storage
- zero padding
- a page crossing inside the ring
- a crossing through the ring limit back to the first page

A frame started with cur_page equal to the limit page checks the relocation of the start page. A broadcast with acceptance off, an accepted broadcast, a multicast frame, and a near-broadcast that fails at its sixth byte show that the filter acts on the right byte and leaves status alone.

A long frame run into the guard page shows the overrun path. The unicast frame that follows shows recovery from it. Masked and cleared status bits check the interrupt line.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_PAD,
        ST_HDR,
        ST_SKIP
    } wr_state_e;

    localparam int          HDR_BYTES  = 4;
    localparam int          DEST_BYTES = 6;
    localparam int          OFS_W      = 8;
    localparam int          IS_W       = 8;
    localparam int          IS_DONE    = 0;
    localparam int          IS_OVRN    = 4;
    localparam logic [7:0]  RS_OK      = 8'h01;
    localparam logic [7:0]  RS_GROUP   = 8'h20;
    localparam logic [7:0]  RS_OVRN    = 8'h10;
    localparam logic [7:0]  BCAST_BYTE = 8'hFF;

endpackage

// File: rtl/rxring_addr_step.sv
module rxring_addr_step #(
    parameter int PG_W  = 8,
    parameter int OFS_W = 8
) (
    input  logic [PG_W+OFS_W-1:0] ptr_i,
    input  logic [PG_W-1:0]       pg_first_i,
    input  logic [PG_W-1:0]       pg_last_i,
    input  logic [PG_W-1:0]       pg_guard_i,
    output logic [PG_W+OFS_W-1:0] ptr_o,
    output logic                  cross_o,
    output logic                  hit_guard_o
);
    localparam int AW = PG_W + OFS_W;

    logic [AW-1:0]   inc;
    logic [PG_W-1:0] pg_raw;
    logic [PG_W-1:0] pg_wrap;

    always_comb begin
        inc         = ptr_i + AW'(1);
        cross_o     = (inc[OFS_W-1:0] == '0);
        pg_raw      = inc[AW-1:OFS_W];
        pg_wrap     = (cross_o && (pg_raw == pg_last_i)) ? pg_first_i : pg_raw;
        ptr_o       = {pg_wrap, inc[OFS_W-1:0]};
        hit_guard_o = cross_o && (pg_wrap == pg_guard_i);
    end

endmodule

// File: rtl/rxring_dest_filter.sv
module rxring_dest_filter #(
    parameter int LEN_W      = 16,
    parameter int DEST_BYTES = 6
) (
    input  logic [7:0]       byte_i,
    input  logic             first_i,
    input  logic [LEN_W-1:0] idx_i,
    input  logic             grp_q_i,
    input  logic             accept_bcast_i,
    output logic             grp_o,
    output logic             reject_o
);
    logic in_dest;
    logic all_ones;

    always_comb begin
        grp_o    = first_i ? byte_i[0] : grp_q_i;
        in_dest  = first_i || (idx_i < LEN_W'(DEST_BYTES));
        all_ones = (byte_i == 8'hFF);
        reject_o = grp_o && in_dest && (!accept_bcast_i || !all_ones);
    end

endmodule

// File: rtl/rxring_irq_regs.sv
module rxring_irq_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    logic [W-1:0] status_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[b] <= 1'b0;
            else if (set_i[b])
                status_q[b] <= 1'b1;
            else if (clr_i[b])
                status_q[b] <= 1'b0;
        end
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & mask_i);

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 8,
    parameter int MIN_FRAME = 60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic [7:0]            rx_data,
    input  logic [PG_W-1:0]       pg_first,
    input  logic [PG_W-1:0]       pg_last,
    input  logic [PG_W-1:0]       pg_guard,
    input  logic                  accept_bcast,
    input  logic                  cur_wr_en,
    input  logic [PG_W-1:0]       cur_wr_val,
    input  logic [IS_W-1:0]       int_status_clr,
    input  logic [IS_W-1:0]       int_mask,
    output logic                  mem_we,
    output logic [PG_W+OFS_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       cur_page,
    output logic [7:0]            rx_status,
    output logic [IS_W-1:0]       int_status,
    output logic [CNT_W-1:0]      missed_cnt,
    output logic                  irq,
    output logic                  rx_busy
);
    localparam int               AW      = PG_W + OFS_W;
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);
    localparam int               HIX_W   = $clog2(HDR_BYTES);
    localparam logic [HIX_W-1:0] HIX_END = HIX_W'(HDR_BYTES - 1);

    wr_state_e state_q, state_d;

    logic [AW-1:0]    ptr_q;
    logic [PG_W-1:0]  start_q;
    logic [LEN_W-1:0] len_q;
    logic             grp_q;
    logic [HIX_W-1:0] hix_q;
    logic [PG_W-1:0]  cur_q;
    logic [7:0]       rs_q;
    logic [CNT_W-1:0] miss_q;

    // Byte acceptance and write address
    logic             in_idle;
    logic             take;
    logic [PG_W-1:0]  start_now;
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    nxt_ptr;
    logic             crossed;
    logic             guard_hit;
    logic             grp_now;
    logic             reject;
    logic             keep;
    logic             ovrn;
    logic [LEN_W-1:0] len_now;

    // Header values
    logic [PG_W-1:0]  nxt_pg_raw;
    logic [PG_W-1:0]  nxt_pg;
    logic [LEN_W-1:0] len_tot;
    logic [7:0]       hdr_rs;
    logic             commit;
    logic [IS_W-1:0]  is_set;

    always_comb begin
        in_idle   = (state_q == ST_IDLE);
        take      = rx_valid && ((in_idle && rx_sof) || (state_q == ST_RECV));
        start_now = (cur_q == pg_last) ? pg_first : cur_q;
        wr_ptr    = in_idle ? {start_now, OFS_W'(HDR_BYTES)} : ptr_q;
        len_now   = in_idle ? LEN_W'(1) : len_q + LEN_W'(1);
    end

    rxring_addr_step #(
        .PG_W  (PG_W),
        .OFS_W (OFS_W)
    ) u_step (
        .ptr_i       (wr_ptr),
        .pg_first_i  (pg_first),
        .pg_last_i   (pg_last),
        .pg_guard_i  (pg_guard),
        .ptr_o       (nxt_ptr),
        .cross_o     (crossed),
        .hit_guard_o (guard_hit)
    );

    rxring_dest_filter #(
        .LEN_W      (LEN_W),
        .DEST_BYTES (DEST_BYTES)
    ) u_filt (
        .byte_i         (rx_data),
        .first_i        (in_idle),
        .idx_i          (len_q),
        .grp_q_i        (grp_q),
        .accept_bcast_i (accept_bcast),
        .grp_o          (grp_now),
        .reject_o       (reject)
    );

    always_comb begin
        keep       = take && !reject;
        ovrn       = keep && crossed && guard_hit;
        nxt_pg_raw = ptr_q[AW-1:OFS_W] + PG_W'(ptr_q[OFS_W-1:0] != '0);
        nxt_pg     = (nxt_pg_raw == pg_last) ? pg_first : nxt_pg_raw;
        len_tot    = len_q + HDR_LEN;
        hdr_rs     = RS_OK | (grp_q ? RS_GROUP : 8'h00);
        commit     = (state_q == ST_HDR) && (hix_q == HIX_END);
        is_set          = '0;
        is_set[IS_DONE] = commit;
        is_set[IS_OVRN] = ovrn;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RECV: begin
                if (take) begin
                    if (reject || ovrn)
                        state_d = rx_eof ? ST_IDLE : ST_SKIP;
                    else if (rx_eof)
                        state_d = (len_now < MIN_LEN) ? ST_PAD : ST_HDR;
                    else
                        state_d = ST_RECV;
                end
            end
            ST_PAD: begin
                if (len_q + LEN_W'(1) >= MIN_LEN)
                    state_d = ST_HDR;
            end
            ST_HDR: begin
                if (hix_q == HIX_END)
                    state_d = ST_IDLE;
            end
            ST_SKIP: begin
                if (rx_valid && rx_eof)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            start_q <= '0;
            len_q   <= '0;
            grp_q   <= 1'b0;
            hix_q   <= '0;
        end else begin
            if (take && in_idle)
                start_q <= start_now;
            if (take) begin
                grp_q <= grp_now;
                len_q <= len_now;
            end
            if (keep || (state_q == ST_PAD))
                ptr_q <= nxt_ptr;
            if (state_q == ST_PAD)
                len_q <= len_q + LEN_W'(1);
            if (state_q == ST_HDR)
                hix_q <= hix_q + HIX_W'(1);
            else
                hix_q <= '0;
        end
    end

    // Frame results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            rs_q   <= '0;
            miss_q <= '0;
        end else begin
            if (commit)
                cur_q <= nxt_pg;
            else if (cur_wr_en)
                cur_q <= cur_wr_val;
            if (commit)
                rs_q <= hdr_rs;
            else if (ovrn)
                rs_q <= RS_OVRN;
            if (ovrn)
                miss_q <= miss_q + CNT_W'(1);
        end
    end

    // Output process: registered memory port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_RECV: begin
                    if (keep) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wr_ptr;
                        mem_wdata <= rx_data;
                    end
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= ptr_q;
                    mem_wdata <= 8'h00;
                end
                ST_HDR: begin
                    mem_we   <= 1'b1;
                    mem_addr <= {start_q, OFS_W'(hix_q)};
                    unique case (hix_q)
                        2'd0:    mem_wdata <= hdr_rs;
                        2'd1:    mem_wdata <= 8'(nxt_pg);
                        2'd2:    mem_wdata <= len_tot[7:0];
                        default: mem_wdata <= len_tot[15:8];
                    endcase
                end
                default: ;
            endcase
        end
    end

    rxring_irq_regs #(
        .W (IS_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (is_set),
        .clr_i    (int_status_clr),
        .mask_i   (int_mask),
        .status_o (int_status),
        .irq_o    (irq)
    );

    assign cur_page   = cur_q;
    assign rx_status  = rs_q;
    assign missed_cnt = miss_q;
    assign rx_busy    = (state_q == ST_PAD) || (state_q == ST_HDR);

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
    parameter int PG_W  = 8,
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [PG_W+7:0]   mem_addr,
    input logic [PG_W-1:0]   pg_first,
    input logic [PG_W-1:0]   pg_last,
    input logic [PG_W-1:0]   cur_page,
    input logic              cur_wr_en,
    input logic [7:0]        rx_status,
    input logic [7:0]        int_status,
    input logic [CNT_W-1:0]  missed_cnt,
    input logic              irq,
    input logic              rx_busy
);
    // R3: every write lands inside the ring
    p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PG_W+7:8] >= pg_first && mem_addr[PG_W+7:8] < pg_last));

    // R4: the missed counter only ever steps by one
    p_miss_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == $past(missed_cnt) + 1'b1));

    // R4: an overrun always flags its status bit
    p_miss_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt != $past(missed_cnt)) |-> (int_status[4] && rx_status == 8'h10));

    // R7: the busy period ends with the last header write
    p_hdr_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_busy) |-> mem_we);

    // R8: an internal advance of the current page comes with the done flag
    p_cur_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_page != $past(cur_page) && !$past(cur_wr_en)) |-> int_status[0]);

    // R9: no interrupt without a pending status bit
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_status != 8'h00));

endmodule

bind rxring_writer rxring_writer_chk #(.PG_W(PG_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pg_first   (pg_first),
    .pg_last    (pg_last),
    .cur_page   (cur_page),
    .cur_wr_en  (cur_wr_en),
    .rx_status  (rx_status),
    .int_status (int_status),
    .missed_cnt (missed_cnt),
    .irq        (irq),
    .rx_busy    (rx_busy)
);

// File: tb/rxring_writer_bench.sv
`timescale 1ns/1ps
module rxring_writer_bench;
    localparam logic [7:0] PG_FIRST = 8'h40;
    localparam logic [7:0] PG_LAST  = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [7:0]  pg_guard = 8'h4C;
    logic        accept_bcast = 1'b0;
    logic        cur_wr_en = 1'b0;
    logic [7:0]  cur_wr_val = 8'h00;
    logic [7:0]  int_status_clr = 8'h00;
    logic [7:0]  int_mask = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_page, rx_status, int_status, missed_cnt;
    logic        irq, rx_busy;

    always #2.5 clk = ~clk;

    rxring_writer u_rxring_writer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .pg_first(PG_FIRST), .pg_last(PG_LAST),
        .pg_guard(pg_guard), .accept_bcast(accept_bcast), .cur_wr_en(cur_wr_en),
        .cur_wr_val(cur_wr_val), .int_status_clr(int_status_clr), .int_mask(int_mask),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .rx_status(rx_status), .int_status(int_status),
        .missed_cnt(missed_cnt), .irq(irq), .rx_busy(rx_busy)
    );

    int total = 0;
    int bad = 0;
    int wr_seen = 0;
    int cyc = 0;
    logic [23:0] exp_q[$];
    logic [7:0]  frm[$];
    logic [7:0]  m_cur = 8'h00, m_rs = 8'h00, m_isr = 8'h00, m_miss = 8'h00;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every memory write is matched in order
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            wr_seen++;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 write act=%h:%h exp=none", mem_addr, mem_wdata);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    bad++;
                    $display("FAIL R2/R7 write act=%h:%h exp=%h:%h",
                             mem_addr, mem_wdata, e[23:8], e[7:0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic build(input int n, input logic [7:0] first, input logic [7:0] seed);
        frm.delete();
        for (int i = 0; i < n; i++)
            frm.push_back(i == 0 ? first : 8'(seed + i * 13));
    endtask

    task automatic build_bytes(input logic [7:0] b0, input logic [7:0] b5, input int n);
        frm.delete();
        for (int i = 0; i < n; i++)
            frm.push_back(i == 0 ? b0 : (i < 5 ? 8'hFF : (i == 5 ? b5 : 8'(i))));
    endtask

    task automatic load_cur(input logic [7:0] v);
        @(negedge clk);
        cur_wr_en = 1'b1;
        cur_wr_val = v;
        @(negedge clk);
        cur_wr_en = 1'b0;
        m_cur = v;
    endtask

    // Driver: predicts the frame's writes into the scoreboard, then sends it
    task automatic send_frame(input bit poke);
        logic [15:0] off;
        logic [7:0]  sp, pg, np;
        int          n, w0;
        bit          grp, drop, ovf;
        string       tag;
        sp = (m_cur == PG_LAST) ? PG_FIRST : m_cur;
        off = {sp, 8'h04};
        grp = 1'b0; drop = 1'b0; ovf = 1'b0; n = 0;
        foreach (frm[i]) begin
            if (i == 0) grp = frm[0][0];
            if (grp && i < 6 && (!accept_bcast || frm[i] != 8'hFF)) begin
                drop = 1'b1;
                break;
            end
            exp_q.push_back({off, frm[i]});
            off = off + 16'd1;
            n++;
            if (off[7:0] == 8'h00) begin
                pg = off[15:8];
                if (pg == PG_LAST) pg = PG_FIRST;
                off = {pg, 8'h00};
                if (pg == pg_guard) begin
                    ovf = 1'b1;
                    break;
                end
            end
        end
        if (ovf) begin
            m_rs = 8'h10; m_isr = m_isr | 8'h10; m_miss = m_miss + 8'd1; tag = "R4";
        end else if (drop) begin
            tag = "R5";
        end else begin
            while (n < 60) begin
                exp_q.push_back({off, 8'h00});
                off = off + 16'd1;
                n++;
            end
            np = off[15:8] + ((off[7:0] != 8'h00) ? 8'd1 : 8'd0);
            if (np == PG_LAST) np = PG_FIRST;
            m_rs = grp ? 8'h21 : 8'h01;
            exp_q.push_back({sp, 8'h00, m_rs});
            exp_q.push_back({sp, 8'h01, np});
            exp_q.push_back({sp, 8'h02, 8'(n + 4)});
            exp_q.push_back({sp, 8'h03, 8'((n + 4) >> 8)});
            m_cur = np; m_isr = m_isr | 8'h01; tag = "R8";
        end
        w0 = wr_seen;
        foreach (frm[i]) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == frm.size() - 1);
            rx_data = frm[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (poke) begin
            // R10: a byte offered during padding is ignored
            chk("R10 busy", rx_busy, 1);
            rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h55;
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        end
        while (rx_busy) @(negedge clk);
        @(negedge clk);
        #1;
        chk({tag, " cur_page"}, cur_page, m_cur);
        chk({tag, " rx_status"}, rx_status, m_rs);
        chk({tag, " int_status"}, int_status, m_isr);
        chk({tag, " missed_cnt"}, missed_cnt, m_miss);
        chk({tag, " pending writes"}, exp_q.size(), 0);
        frame_writes = wr_seen - w0;
    endtask

    int frame_writes = 0;

    task automatic clear_isr(input logic [7:0] v);
        @(negedge clk);
        int_status_clr = v;
        @(negedge clk);
        int_status_clr = 8'h00;
        m_isr = m_isr & ~v;
        #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 mem_we", mem_we, 0);
        chk("R1 busy", rx_busy, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cur_page", cur_page, 0);
        chk("R1 status", {rx_status, int_status, missed_cnt}, 0);
        rst_n = 1'b1;

        load_cur(8'h40);
        build(64, 8'h02, 8'h11);               // R2 plain unicast
        send_frame(1'b0);
        chk("R2 writes", frame_writes, 68);

        build(20, 8'h02, 8'h33);               // R6 short frame, R10 poke
        send_frame(1'b1);
        chk("R6 padded writes", frame_writes, 64);

        build(300, 8'h02, 8'h5A);              // R3 crossing inside the ring
        send_frame(1'b0);
        chk("R3 next page", cur_page, 8'h44);

        load_cur(8'h4F);                       // R3 crossing through the limit
        build(400, 8'h02, 8'h77);
        send_frame(1'b0);
        chk("R3 wrapped page", cur_page, 8'h41);

        load_cur(PG_LAST);                     // R2 start relocated to pg_first
        build(30, 8'h02, 8'h09);
        send_frame(1'b0);
        chk("R2 relocated", cur_page, 8'h41);

        accept_bcast = 1'b0;                   // R5 broadcast refused
        build_bytes(8'hFF, 8'hFF, 70);
        send_frame(1'b0);
        chk("R5 refused writes", frame_writes, 0);

        accept_bcast = 1'b1;                   // R7 broadcast accepted
        send_frame(1'b0);
        chk("R7 bcast status", rx_status, 8'h21);

        build(70, 8'h01, 8'h00);               // R5 multicast dropped
        send_frame(1'b0);
        chk("R5 multicast writes", frame_writes, 0);

        build_bytes(8'hFF, 8'h00, 70);         // R5 fails at sixth byte
        send_frame(1'b0);
        chk("R5 partial writes", frame_writes, 5);

        load_cur(8'h44);                       // R4 overrun into guard page
        pg_guard = 8'h46;
        build(600, 8'h02, 8'h21);
        send_frame(1'b0);
        chk("R4 overrun writes", frame_writes, 508);

        pg_guard = 8'h4C;                      // recovery after overrun
        build(64, 8'h02, 8'h44);
        send_frame(1'b0);
        chk("R8 recovered page", cur_page, 8'h45);

        // R9 interrupt masking and clearing
        int_mask = 8'h00; #1;
        chk("R9 masked irq", irq, 0);
        int_mask = 8'h10; #1;
        chk("R9 ovrn irq", irq, 1);
        clear_isr(8'h10);
        chk("R9 cleared status", int_status, 8'h01);
        chk("R9 irq after clear", irq, 0);
        int_mask = 8'h01; #1;
        chk("R9 done irq", irq, 1);
        clear_isr(8'h01);
        chk("R9 all clear", int_status, 8'h00);
        chk("R9 irq low", irq, 0);

        repeat (3) @(negedge clk);
        chk("R2 no stray writes", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule